// File: doc/BRIEF.md
# Disc Data Controller Register Window

This block is the byte-wide register window of a disc data controller. A host reaches every internal register through two things: a 5-bit index, loaded by a separate address strobe, and a single data port. Each read or write acts on the register the index selects, and the index then moves forward by one. The read side and the write side decode different register maps. A host can therefore stream through a whole group of registers with one index load.

The window holds the interface control and interface status bytes, a transfer byte counter, a transfer data address, a buffer write address, a block pointer, two control registers, two banks of header bytes and the decoder status registers. Some accesses have side effects. Reading the last status register clears the decoder interrupt. Writing the acknowledge slot clears the transfer-end interrupt. Writing interface control re-evaluates the interrupt line.

The decoder and the transfer datapath are outside this block. The decoder connects through an event strobe with a header word. The datapath connects through a start pulse, an end strobe, a host-read mode level, and the address and count outputs.

Top module: `disc_regwin`

## Requirements
- R1: `idx_wr` loads `idx_wdata` into the index, and this takes priority over an access in the same cycle, which is then ignored. Every other read or write advances the index by one, modulo 32. An access at index 0 leaves the index at 0.
- R2: `rdata` is registered. It changes only in the cycle after a read strobe and otherwise holds its value. When `rd_stb` and `wr_stb` are both high, only the write is performed.
- R3: The read map by index is: 1 interface status, 2/3 counter low/high, 4..7 header bytes 0..3, 8/9 pointer low/high, 10/11 write address low/high, 12 status 0, 13 status 1 (always 0x00), 14 status 2, 15 status 3. Index 0 and indices 16..31 read 0xFF.
- R4: After `rst`, the index, `rdata`, `irq`, `xfer_start`, the counter, both addresses and the pointer are 0. Interface status is 0xFF and status 3 is 0x80. Header bank 0 reads 00,00,00,01 and bank 1 reads all zero. Status 0 and status 2 read 0.
- R5: A write at index 15 restores every register to its R4 value, drops `irq` and sets the index to 0.
- R6: Interface status is active-low: bit 6 is the transfer-end pending flag and bit 5 is the decoder pending flag. A write at index 1 (interface control: bit 6 transfer-end enable, bit 5 decoder enable, bit 1 output enable) sets `irq` to 1 if an enabled source is pending and clears it otherwise.
- R7: A write at index 1 with bit 1 at 0 sets interface status bit 3 (busy) and bit 1 (data ready) to 1.
- R8: A write at index 3 keeps only data bits 3:0 as counter bits 11:8 and zeroes bits 15:12. A write at index 7 sets interface status bit 6 to 1 and zeroes counter bits 15:12.
- R9: Status 2 is recomputed on every write at index 10 (control 0) or 11 (control 1). It holds control 1 bit 3 in bit 3. It holds control 1 bit 2 in bit 2 only while control 0 bit 4 is 0. All other bits are 0.
- R10: A write at index 10 with bit 7 at 0 sets interface status bit 5 to 1. A read at index 15 returns status 3, then sets status 3 to 0x80 and interface status bit 5 to 1.
- R11: Header reads (index 4..7) return bank 1 when control 1 bit 0 is 1 and bank 0 otherwise.
- R12: A `dec_evt` pulse while control 0 bit 7 is 1 loads header bank 0 byte k from `dec_hdr[8k+7:8k]`. It also sets status 3 to 0x00 and status 0 to 0x80, clears interface status bit 5, and raises `irq` if interface control bit 5 is 1. While control 0 bit 7 is 0 the pulse changes nothing.
- R13: Writes at index 4/5 set the low/high bytes of `xfer_addr`. A write at index 6 with interface control bit 1 at 1 pulses `xfer_start` for one cycle, zeroes counter bits 15:12, clears status bit 3 and sets status bit 1 to the inverse of `host_read`; with bit 1 at 0 it does nothing. An `xfer_end` pulse sets the counter to 0xFFFF, sets status bits 3 and 1, clears bit 6, and raises `irq` if interface control bit 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Address strobe, loads the index |
| idx_wdata | input | 5 | New index value |
| rd_stb | input | 1 | Single-cycle register read strobe |
| wr_stb | input | 1 | Single-cycle register write strobe |
| wdata | input | 8 | Register write data |
| dec_evt | input | 1 | Decoder block-decoded strobe |
| dec_hdr | input | 32 | Header bytes from the decoder, byte k in bits 8k+7:8k |
| xfer_end | input | 1 | Transfer datapath finished strobe |
| host_read | input | 1 | Transfer destination is a host read |
| rdata | output | 8 | Registered read data |
| idx_o | output | 5 | Current index |
| irq | output | 1 | Interrupt request |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_addr | output | 16 | Transfer data address |
| xfer_count | output | 16 | Transfer byte counter |

## Verification
The bound checker checks the following on every cycle:
- the index step, the index hold at slot 0, and the index load;
- that `rdata` holds its value when no read is performed;
- the constant reads of the blank slots and status 1;
- the interrupt decision on every interface-control write;
- the effects of the clear and acknowledge slots;
- that `xfer_start` appears only after a trigger write.

Only the bench scenarios can show the value-carrying behaviour: the register contents read back through the map, the status 2 mode masking, the header bank selection, the decoder event being ignored while decoding is off, the status 3 read side effect, and the full reset values.

// File: rtl/disc_regwin_pkg.sv
package disc_regwin_pkg;

    localparam int IDX_W  = 5;
    localparam int DW     = 8;
    localparam int CNT_W  = 16;
    localparam int HDR_N  = 4;
    localparam int HDR_W  = HDR_N * DW;

    // interface status / control bit positions
    localparam int IFS_DTE = 6;
    localparam int IFS_DEC = 5;
    localparam int IFS_BSY = 3;
    localparam int IFS_RDY = 1;
    localparam int IFC_OUT = 1;

    localparam logic [DW-1:0] ST3_IDLE = 8'h80;
    localparam logic [DW-1:0] ST0_OK   = 8'h80;
    localparam logic [DW-1:0] BLANK    = 8'hFF;

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [IDX_W-1:0] {
        W_NONE  = 5'd0,  W_IFCTL = 5'd1,  W_CNTL = 5'd2,  W_CNTH  = 5'd3,
        W_DADL  = 5'd4,  W_DADH  = 5'd5,  W_TRIG = 5'd6,  W_ACK   = 5'd7,
        W_WADL  = 5'd8,  W_WADH  = 5'd9,  W_CTL0 = 5'd10, W_CTL1  = 5'd11,
        W_PTRL  = 5'd12, W_PTRH  = 5'd13, W_SPARE = 5'd14, W_CLR  = 5'd15
    } wslot_e;

    typedef enum logic [IDX_W-1:0] {
        R_NONE  = 5'd0,  R_IFSTAT = 5'd1, R_CNTL = 5'd2,  R_CNTH = 5'd3,
        R_HDR0  = 5'd4,  R_HDR1   = 5'd5, R_HDR2 = 5'd6,  R_HDR3 = 5'd7,
        R_PTRL  = 5'd8,  R_PTRH   = 5'd9, R_WADL = 5'd10, R_WADH = 5'd11,
        R_ST0   = 5'd12, R_ST1    = 5'd13, R_ST2 = 5'd14, R_ST3  = 5'd15
    } rslot_e;

    typedef struct packed {
        logic [DW-1:0]    ifstat;
        logic             ie_dte;
        logic             ie_dec;
        logic             out_en;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dad;
        logic [CNT_W-1:0] wad;
        logic [CNT_W-1:0] ptr;
        logic             dec_en;
        logic             auto_md;
        logic             c1_mode;
        logic             c1_form;
        logic             c1_bank;
        logic [DW-1:0]    st0;
        logic [DW-1:0]    st2;
        logic [DW-1:0]    st3;
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r        = '0;
        r.ifstat = BLANK;
        r.st3    = ST3_IDLE;
        return r;
    endfunction

    // status 2: MODE always follows control 1, FORM masked in auto mode
    function automatic logic [DW-1:0] mode_status(input logic auto_md,
                                                  input logic mode,
                                                  input logic form);
        return {4'b0000, mode, form & ~auto_md, 2'b00};
    endfunction

endpackage

// File: rtl/disc_regwin_index.sv
module disc_regwin_index
    import disc_regwin_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    input  logic         clr,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (ld) begin
            idx <= ld_val;
        end else if (clr) begin
            idx <= '0;
        end else if (step && (idx != '0)) begin
            idx <= idx + ONE;
        end
    end
endmodule

// File: rtl/disc_regwin_core.sv
module disc_regwin_core
    import disc_regwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  idx_t             idx,
    input  logic             rd_go,
    input  logic             wr_go,
    input  logic [DW-1:0]    wdata,
    input  logic             dec_evt,
    input  logic [HDR_W-1:0] dec_hdr,
    input  logic             xfer_end,
    input  logic             host_read,
    output logic [DW-1:0]    rdata,
    output logic             xfer_start,
    output logic [DW-1:0]    ifstat,
    output logic             ie_dte,
    output logic             ie_dec,
    output logic             dec_hit,
    output logic [CNT_W-1:0] xfer_addr,
    output logic [CNT_W-1:0] xfer_count
);
    regs_t         r;
    logic [DW-1:0] hdr0 [HDR_N];
    logic [DW-1:0] hdr1 [HDR_N];
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] hdr_byte;

    assign dec_hit = dec_evt && r.dec_en;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            r          <= regs_reset();
            xfer_start <= 1'b0;
            for (int k = 0; k < HDR_N; k++) begin
                hdr0[k] <= (k == HDR_N - 1) ? DW'(1) : '0;
                hdr1[k] <= '0;
            end
        end else begin
            xfer_start <= 1'b0;
            if (wr_go) begin
                case (wslot_e'(idx))
                    W_IFCTL: begin
                        r.ie_dte <= wdata[IFS_DTE];
                        r.ie_dec <= wdata[IFS_DEC];
                        r.out_en <= wdata[IFC_OUT];
                        if (!wdata[IFC_OUT]) begin
                            r.ifstat[IFS_BSY] <= 1'b1;
                            r.ifstat[IFS_RDY] <= 1'b1;
                        end
                    end
                    W_CNTL:  r.cnt[DW-1:0]     <= wdata;
                    W_CNTH:  r.cnt[CNT_W-1:DW] <= {4'h0, wdata[3:0]};
                    W_DADL:  r.dad[DW-1:0]     <= wdata;
                    W_DADH:  r.dad[CNT_W-1:DW] <= wdata;
                    W_TRIG: begin
                        if (r.out_en) begin
                            r.ifstat[IFS_BSY] <= 1'b0;
                            r.ifstat[IFS_RDY] <= ~host_read;
                            r.cnt[CNT_W-1:CNT_W-4] <= 4'h0;
                            xfer_start <= 1'b1;
                        end
                    end
                    W_ACK: begin
                        r.ifstat[IFS_DTE]      <= 1'b1;
                        r.cnt[CNT_W-1:CNT_W-4] <= 4'h0;
                    end
                    W_WADL:  r.wad[DW-1:0]     <= wdata;
                    W_WADH:  r.wad[CNT_W-1:DW] <= wdata;
                    W_CTL0: begin
                        r.dec_en  <= wdata[7];
                        r.auto_md <= wdata[4];
                        if (!wdata[7]) r.ifstat[IFS_DEC] <= 1'b1;
                        r.st2 <= mode_status(wdata[4], r.c1_mode, r.c1_form);
                    end
                    W_CTL1: begin
                        r.c1_mode <= wdata[3];
                        r.c1_form <= wdata[2];
                        r.c1_bank <= wdata[0];
                        r.st2 <= mode_status(r.auto_md, wdata[3], wdata[2]);
                    end
                    W_PTRL:  r.ptr[DW-1:0]     <= wdata;
                    W_PTRH:  r.ptr[CNT_W-1:DW] <= wdata;
                    default: ;
                endcase
            end else if (rd_go && (rslot_e'(idx) == R_ST3)) begin
                r.st3             <= ST3_IDLE;
                r.ifstat[IFS_DEC] <= 1'b1;
            end

            // events from the decoder and the transfer datapath
            if (dec_hit) begin
                for (int k = 0; k < HDR_N; k++) hdr0[k] <= dec_hdr[k*DW +: DW];
                r.st3             <= '0;
                r.st0             <= ST0_OK;
                r.ifstat[IFS_DEC] <= 1'b0;
            end
            if (xfer_end) begin
                r.cnt             <= '1;
                r.ifstat[IFS_BSY] <= 1'b1;
                r.ifstat[IFS_RDY] <= 1'b1;
                r.ifstat[IFS_DTE] <= 1'b0;
            end
        end
    end

    assign hdr_byte = r.c1_bank ? hdr1[idx[1:0]] : hdr0[idx[1:0]];

    always_comb begin
        case (rslot_e'(idx))
            R_IFSTAT: rd_mux = r.ifstat;
            R_CNTL:   rd_mux = r.cnt[DW-1:0];
            R_CNTH:   rd_mux = r.cnt[CNT_W-1:DW];
            R_HDR0, R_HDR1, R_HDR2, R_HDR3: rd_mux = hdr_byte;
            R_PTRL:   rd_mux = r.ptr[DW-1:0];
            R_PTRH:   rd_mux = r.ptr[CNT_W-1:DW];
            R_WADL:   rd_mux = r.wad[DW-1:0];
            R_WADH:   rd_mux = r.wad[CNT_W-1:DW];
            R_ST0:    rd_mux = r.st0;
            R_ST1:    rd_mux = '0;
            R_ST2:    rd_mux = r.st2;
            R_ST3:    rd_mux = r.st3;
            default:  rd_mux = BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_go) rdata <= rd_mux;
    end

    assign ifstat     = r.ifstat;
    assign ie_dte     = r.ie_dte;
    assign ie_dec     = r.ie_dec;
    assign xfer_addr  = r.dad;
    assign xfer_count = r.cnt;
endmodule

// File: rtl/disc_regwin_irq.sv
module disc_regwin_irq (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic ifc_wr,
    input  logic new_dte_en,
    input  logic new_dec_en,
    input  logic dte_pend_n,
    input  logic dec_pend_n,
    input  logic ie_dte,
    input  logic ie_dec,
    input  logic dec_hit,
    input  logic xfer_end,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            irq <= 1'b0;
        end else if (ifc_wr) begin
            irq <= (new_dte_en && !dte_pend_n) || (new_dec_en && !dec_pend_n);
        end else if ((dec_hit && ie_dec) || (xfer_end && ie_dte)) begin
            irq <= 1'b1;
        end
    end
endmodule

// File: rtl/disc_regwin.sv
module disc_regwin
    import disc_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  idx_wdata,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DW-1:0]     wdata,
    input  logic              dec_evt,
    input  logic [HDR_W-1:0]  dec_hdr,
    input  logic              xfer_end,
    input  logic              host_read,
    output logic [DW-1:0]     rdata,
    output logic [IDX_W-1:0]  idx_o,
    output logic              irq,
    output logic              xfer_start,
    output logic [CNT_W-1:0]  xfer_addr,
    output logic [CNT_W-1:0]  xfer_count
);
    logic          wr_go, rd_go, acc, clr, ifc_wr;
    logic          ie_dte, ie_dec, dec_hit;
    logic [DW-1:0] ifstat_w;

    assign wr_go  = wr_stb && !idx_wr;
    assign rd_go  = rd_stb && !wr_stb && !idx_wr;
    assign acc    = wr_go || rd_go;
    assign clr    = wr_go && (wslot_e'(idx_o) == W_CLR);
    assign ifc_wr = wr_go && (wslot_e'(idx_o) == W_IFCTL);

    disc_regwin_index #(.W(IDX_W)) u_idx (
        .clk    (clk),
        .rst    (rst),
        .ld     (idx_wr),
        .ld_val (idx_wdata),
        .step   (acc),
        .clr    (clr),
        .idx    (idx_o)
    );

    disc_regwin_core u_core (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .idx        (idx_o),
        .rd_go      (rd_go),
        .wr_go      (wr_go),
        .wdata      (wdata),
        .dec_evt    (dec_evt),
        .dec_hdr    (dec_hdr),
        .xfer_end   (xfer_end),
        .host_read  (host_read),
        .rdata      (rdata),
        .xfer_start (xfer_start),
        .ifstat     (ifstat_w),
        .ie_dte     (ie_dte),
        .ie_dec     (ie_dec),
        .dec_hit    (dec_hit),
        .xfer_addr  (xfer_addr),
        .xfer_count (xfer_count)
    );

    disc_regwin_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .ifc_wr     (ifc_wr),
        .new_dte_en (wdata[IFS_DTE]),
        .new_dec_en (wdata[IFS_DEC]),
        .dte_pend_n (ifstat_w[IFS_DTE]),
        .dec_pend_n (ifstat_w[IFS_DEC]),
        .ie_dte     (ie_dte),
        .ie_dec     (ie_dec),
        .dec_hit    (dec_hit),
        .xfer_end   (xfer_end),
        .irq        (irq)
    );
endmodule

// File: rtl/disc_regwin_chk.sv
module disc_regwin_chk (
    input logic        clk,
    input logic        rst,
    input logic        idx_wr,
    input logic [4:0]  idx_wdata,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [7:0]  wdata,
    input logic        xfer_end,
    input logic [4:0]  idx_o,
    input logic [7:0]  rdata,
    input logic        irq,
    input logic        xfer_start,
    input logic [7:0]  ifstat_w,
    input logic [15:0] xfer_count
);
    logic rd_ok, wr_ok;
    assign wr_ok = wr_stb && !idx_wr;
    assign rd_ok = rd_stb && !wr_stb && !idx_wr;

    a_r1_index_step: assert property (@(posedge clk) disable iff (rst)
        (rd_ok || wr_ok) && idx_o != 5'd0 && !(wr_ok && idx_o == 5'd15)
        |=> idx_o == $past(idx_o) + 5'd1);

    a_r1_slot0_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_ok || wr_ok) && idx_o == 5'd0 |=> idx_o == 5'd0);

    a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> idx_o == $past(idx_wdata));

    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_ok |=> $stable(rdata));

    a_r3_blank_slots: assert property (@(posedge clk) disable iff (rst)
        rd_ok && (idx_o == 5'd0 || idx_o[4]) |=> rdata == 8'hFF);

    a_r3_status1_zero: assert property (@(posedge clk) disable iff (rst)
        rd_ok && idx_o == 5'd13 |=> rdata == 8'h00);

    a_r5_soft_clear: assert property (@(posedge clk) disable iff (rst)
        wr_ok && idx_o == 5'd15 |=> idx_o == 5'd0 && !irq && ifstat_w == 8'hFF);

    a_r6_irq_eval: assert property (@(posedge clk) disable iff (rst)
        wr_ok && idx_o == 5'd1 |=>
        irq == (($past(wdata[6]) && !$past(ifstat_w[6])) ||
                ($past(wdata[5]) && !$past(ifstat_w[5]))));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        wr_ok && idx_o == 5'd7 && !xfer_end |=>
        ifstat_w[6] && xfer_count[15:12] == 4'h0);

    a_r13_start_only_on_trigger: assert property (@(posedge clk) disable iff (rst)
        !(wr_ok && idx_o == 5'd6) |=> !xfer_start);
endmodule

bind disc_regwin disc_regwin_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .idx_wr     (idx_wr),
    .idx_wdata  (idx_wdata),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wdata      (wdata),
    .xfer_end   (xfer_end),
    .idx_o      (idx_o),
    .rdata      (rdata),
    .irq        (irq),
    .xfer_start (xfer_start),
    .ifstat_w   (ifstat_w),
    .xfer_count (xfer_count)
);

// File: tb/sim_disc_regwin.sv
`timescale 1ns/1ps
module sim_disc_regwin;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_wr = 1'b0;
    logic [4:0]  idx_wdata = '0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wdata = '0;
    logic        dec_evt = 1'b0;
    logic [31:0] dec_hdr = '0;
    logic        xfer_end = 1'b0;
    logic        host_read = 1'b0;
    logic [7:0]  rdata;
    logic [4:0]  idx_o;
    logic        irq;
    logic        xfer_start;
    logic [15:0] xfer_addr;
    logic [15:0] xfer_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    disc_regwin u0 (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
        .dec_evt(dec_evt), .dec_hdr(dec_hdr), .xfer_end(xfer_end),
        .host_read(host_read), .rdata(rdata), .idx_o(idx_o), .irq(irq),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_count(xfer_count)
    );

    localparam logic [1:0] OP_IDX = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] val;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 51;
    localparam vec_t VEC [NV] = '{
        // R4 / R3: walk the whole read map after reset
        '{OP_IDX, 8'd1,  8'h00, 4'd4},
        '{OP_RD,  8'h00, 8'hFF, 4'd4}, '{OP_RD, 8'h00, 8'h00, 4'd4},
        '{OP_RD,  8'h00, 8'h00, 4'd4}, '{OP_RD, 8'h00, 8'h00, 4'd4},
        '{OP_RD,  8'h00, 8'h00, 4'd4}, '{OP_RD, 8'h00, 8'h00, 4'd4},
        '{OP_RD,  8'h00, 8'h01, 4'd4}, '{OP_RD, 8'h00, 8'h00, 4'd3},
        '{OP_RD,  8'h00, 8'h00, 4'd3}, '{OP_RD, 8'h00, 8'h00, 4'd3},
        '{OP_RD,  8'h00, 8'h00, 4'd3}, '{OP_RD, 8'h00, 8'h00, 4'd4},
        '{OP_RD,  8'h00, 8'h00, 4'd3}, '{OP_RD, 8'h00, 8'h00, 4'd4},
        '{OP_RD,  8'h00, 8'h80, 4'd4}, '{OP_RD, 8'h00, 8'hFF, 4'd3},
        // R8: counter high keeps four bits
        '{OP_IDX, 8'd2,  8'h00, 4'd8}, '{OP_WR, 8'hAB, 8'h00, 4'd8},
        '{OP_WR,  8'hFF, 8'h00, 4'd8}, '{OP_IDX, 8'd2, 8'h00, 4'd8},
        '{OP_RD,  8'h00, 8'hAB, 4'd8}, '{OP_RD, 8'h00, 8'h0F, 4'd8},
        // R3: write address, written at 8/9, read at 10/11
        '{OP_IDX, 8'd8,  8'h00, 4'd3}, '{OP_WR, 8'h34, 8'h00, 4'd3},
        '{OP_WR,  8'h12, 8'h00, 4'd3}, '{OP_IDX, 8'd10, 8'h00, 4'd3},
        '{OP_RD,  8'h00, 8'h34, 4'd3}, '{OP_RD, 8'h00, 8'h12, 4'd3},
        // R3: pointer, written at 12/13, read at 8/9
        '{OP_IDX, 8'd12, 8'h00, 4'd3}, '{OP_WR, 8'h78, 8'h00, 4'd3},
        '{OP_WR,  8'h56, 8'h00, 4'd3}, '{OP_IDX, 8'd8, 8'h00, 4'd3},
        '{OP_RD,  8'h00, 8'h78, 4'd3}, '{OP_RD, 8'h00, 8'h56, 4'd3},
        // R9: status 2 masking by auto mode
        '{OP_IDX, 8'd11, 8'h00, 4'd9}, '{OP_WR, 8'h0C, 8'h00, 4'd9},
        '{OP_IDX, 8'd14, 8'h00, 4'd9}, '{OP_RD, 8'h00, 8'h0C, 4'd9},
        '{OP_IDX, 8'd10, 8'h00, 4'd9}, '{OP_WR, 8'h10, 8'h00, 4'd9},
        '{OP_IDX, 8'd14, 8'h00, 4'd9}, '{OP_RD, 8'h00, 8'h08, 4'd9},
        '{OP_IDX, 8'd11, 8'h00, 4'd9}, '{OP_WR, 8'h0C, 8'h00, 4'd9},
        '{OP_IDX, 8'd14, 8'h00, 4'd9}, '{OP_RD, 8'h00, 8'h08, 4'd9},
        '{OP_IDX, 8'd10, 8'h00, 4'd9}, '{OP_WR, 8'h00, 8'h00, 4'd9},
        '{OP_IDX, 8'd14, 8'h00, 4'd9}, '{OP_RD, 8'h00, 8'h0C, 4'd9}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_idx(input logic [4:0] v);
        @(negedge clk); idx_wr = 1'b1; idx_wdata = v;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wdata = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic do_rd();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] i, input logic [7:0] exp, input string req);
        do_idx(i);
        do_rd();
        check(req, 32'(rdata), 32'(exp));
    endtask

    task automatic pulse_dec(input logic [31:0] h);
        @(negedge clk); dec_evt = 1'b1; dec_hdr = h;
        @(negedge clk); dec_evt = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); xfer_end = 1'b1;
        @(negedge clk); xfer_end = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: port reset state
        check("R4 idx", 32'(idx_o), 32'd0);
        check("R4 irq", 32'(irq), 32'd0);
        check("R4 rdata", 32'(rdata), 32'd0);
        check("R4 count", 32'(xfer_count), 32'd0);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v].op)
                OP_IDX:  do_idx(VEC[v].val[4:0]);
                OP_WR:   do_wr(VEC[v].val);
                default: begin
                    do_rd();
                    check($sformatf("R%0d vec%0d", VEC[v].req, v), 32'(rdata), 32'(VEC[v].exp));
                end
            endcase
        end

        // R1: slot 0 holds, wrap at 31, address strobe wins
        do_idx(5'd0); do_rd();
        check("R1 slot0 idx", 32'(idx_o), 32'd0);
        check("R3 slot0 data", 32'(rdata), 32'hFF);
        do_idx(5'd31); do_rd();
        check("R1 wrap", 32'(idx_o), 32'd0);
        @(negedge clk); idx_wr = 1'b1; idx_wdata = 5'd9; rd_stb = 1'b1;
        @(negedge clk); idx_wr = 1'b0; rd_stb = 1'b0;
        check("R1 strobe priority", 32'(idx_o), 32'd9);
        check("R2 read ignored", 32'(rdata), 32'hFF);
        repeat (3) @(negedge clk);
        check("R2 hold", 32'(rdata), 32'hFF);
        // R2: write wins over read (index 9 = write address high)
        @(negedge clk); wr_stb = 1'b1; rd_stb = 1'b1; wdata = 8'h5A;
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0;
        check("R2 write wins", 32'(rdata), 32'hFF);
        rd_chk(5'd11, 8'h5A, "R2 write done");

        // R12 / R6 / R10 / R11: decoder event
        do_idx(5'd10); do_wr(8'h80);
        pulse_dec(32'h44332211);
        check("R12 no irq when disabled", 32'(irq), 32'd0);
        rd_chk(5'd1, 8'hDF, "R12 dec pending");
        do_idx(5'd1); do_wr(8'h20);
        check("R6 irq pending", 32'(irq), 32'd1);
        do_idx(5'd4);
        do_rd(); check("R12 hdr0", 32'(rdata), 32'h11);
        do_rd(); check("R12 hdr1", 32'(rdata), 32'h22);
        do_rd(); check("R12 hdr2", 32'(rdata), 32'h33);
        do_rd(); check("R12 hdr3", 32'(rdata), 32'h44);
        rd_chk(5'd12, 8'h80, "R12 st0");
        rd_chk(5'd15, 8'h00, "R12 st3");
        rd_chk(5'd15, 8'h80, "R10 st3 reread");
        rd_chk(5'd1, 8'hFF, "R10 pending cleared");
        do_idx(5'd1); do_wr(8'h20);
        check("R6 irq dropped", 32'(irq), 32'd0);
        do_idx(5'd11); do_wr(8'h0D);
        do_idx(5'd4);
        for (int k = 0; k < 4; k++) begin
            do_rd(); check("R11 bank1", 32'(rdata), 32'h00);
        end

        // R12: event ignored with decoding off
        do_idx(5'd10); do_wr(8'h00);
        pulse_dec(32'hDDCCBBAA);
        do_idx(5'd11); do_wr(8'h0C);
        rd_chk(5'd4, 8'h11, "R12 ignored hdr");
        rd_chk(5'd1, 8'hFF, "R12 ignored status");

        // R10: control 0 write with decode off clears pending
        do_idx(5'd10); do_wr(8'h80);
        pulse_dec(32'h0);
        rd_chk(5'd1, 8'hDF, "R10 setup");
        do_idx(5'd10); do_wr(8'h00);
        rd_chk(5'd1, 8'hFF, "R10 ctl0 clears");

        // R13: data address and trigger
        do_idx(5'd4); do_wr(8'hCD); do_wr(8'hAB);
        check("R13 addr", 32'(xfer_addr), 32'hABCD);
        host_read = 1'b1;
        do_idx(5'd1); do_wr(8'h02);
        check("R6 no source", 32'(irq), 32'd0);
        do_idx(5'd2); do_wr(8'h10); do_wr(8'h0F);
        check("R8 count", 32'(xfer_count), 32'h0F10);
        do_idx(5'd6); do_wr(8'h00);
        check("R13 start", 32'(xfer_start), 32'd1);
        @(negedge clk);
        check("R13 start pulse", 32'(xfer_start), 32'd0);
        rd_chk(5'd1, 8'hF5, "R13 busy host");

        // R13 / R8: transfer end and acknowledge
        do_idx(5'd1); do_wr(8'h42);
        check("R6 no dte pending", 32'(irq), 32'd0);
        pulse_end();
        check("R13 end irq", 32'(irq), 32'd1);
        check("R13 end count", 32'(xfer_count), 32'hFFFF);
        rd_chk(5'd1, 8'hBF, "R13 end status");
        do_idx(5'd7); do_wr(8'h00);
        rd_chk(5'd1, 8'hFF, "R8 ack status");
        check("R8 ack count", 32'(xfer_count), 32'h0FFF);

        // R7: abort
        host_read = 1'b0;
        do_idx(5'd6); do_wr(8'h00);
        rd_chk(5'd1, 8'hF7, "R13 busy dma");
        do_idx(5'd1); do_wr(8'h00);
        rd_chk(5'd1, 8'hFF, "R7 abort");
        check("R6 irq off", 32'(irq), 32'd0);

        // R13: trigger ignored without output enable
        do_idx(5'd6); do_wr(8'h00);
        check("R13 no start", 32'(xfer_start), 32'd0);
        rd_chk(5'd1, 8'hFF, "R13 ignored status");

        // R5: soft reset via slot 15
        do_idx(5'd10); do_wr(8'h80);
        pulse_dec(32'h1);
        do_idx(5'd1); do_wr(8'h20);
        check("R5 pre irq", 32'(irq), 32'd1);
        do_idx(5'd15); do_wr(8'h00);
        check("R5 idx", 32'(idx_o), 32'd0);
        check("R5 irq", 32'(irq), 32'd0);
        check("R5 addr", 32'(xfer_addr), 32'd0);
        rd_chk(5'd1, 8'hFF, "R5 ifstat");
        rd_chk(5'd10, 8'h00, "R5 wad");
        rd_chk(5'd15, 8'h80, "R5 st3");
        rd_chk(5'd7, 8'h01, "R5 hdr3");
        rd_chk(5'd14, 8'h00, "R5 st2");

        // R4: hard reset mid-run
        do_idx(5'd9);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R4 idx again", 32'(idx_o), 32'd0);
        check("R4 rdata again", 32'(rdata), 32'd0);

        done = 1'b1;
        report();
    end
endmodule